// File: doc/BRIEF.md
# Real-Time Clock Alarm Flag Controller

This block owns the alarm flag of a real-time clock and the open-drain alarm pin that mirrors it. A one-cycle match strobe from the alarm comparator raises the flag unless the alarm is masked. The flag then pulls the pin low until it is released. How it is released depends on a mode input. In latched mode the processor acknowledges the alarm by reading the flag. In pulse mode the flag falls when software writes a 0 to it, or by itself after a fixed number of timebase ticks.

In latched mode a defer input can hold back the clearing effect of a read. If a read arrives before the short guard window after the alarm has run out, the read is remembered. The flag then drops as soon as the window ends. All timing is counted in ticks of a one-cycle enable derived from a 32.768 kHz clock. The guard window is 4 ticks, about 122 µs. The pulse-mode timeout is a tick-count parameter, 2 ticks by default, about 61 µs.

Top module: `alarm_flag_ctl`

## Requirements
- R1: When the flag is 0, a cycle with `match_i`=1 and `mask_i`=0 sets the flag on the next edge. With `mask_i`=1 the match leaves the flag at 0.
- R2: `pull_en_n_o` is 0 (pin pulled low) exactly while `flag_o` is 1, and 1 (open) while `flag_o` is 0. Both change on the same edge.
- R3: A match that arrives while the flag is already 1 is ignored. It does not restart the tick count that started when the flag was set.
- R4: In latched mode (`latch_mode_i`=1) with `defer_en_i`=0, a read (`rd_i`=1) while the flag is 1 clears it on that edge.
- R5: In latched mode with `defer_en_i`=1, a read made before 4 ticks have been counted since the set does not clear the flag. The flag clears on the first edge after the fourth tick has been counted. A read sampled in the same cycle as the fourth tick still counts as early.
- R6: In latched mode with `defer_en_i`=1, a read made once 4 ticks have been counted clears the flag on that edge. This includes a read in the first cycle after the fourth tick.
- R7: In latched mode, writes (`wr_i` with any `wr_data_i`) have no effect on the flag.
- R8: In pulse mode (`latch_mode_i`=0), reads never clear the flag.
- R9: In pulse mode, a write with `wr_data_i`=0 clears the flag on that edge. A write with `wr_data_i`=1 has no effect.
- R10: In pulse mode, the flag clears by itself on the first edge after RESTORE_TICKS ticks have been counted since the set.
- R11: Synchronous reset clears the flag, any remembered read and both tick counts, and leaves the pin open.
- R12: Ticks are counted only while the flag is 1. A tick in the same cycle as the setting match is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 1 | One-cycle alarm match strobe |
| mask_i | input | 1 | 1 blocks alarm matches |
| latch_mode_i | input | 1 | 1 = latched (read-to-clear), 0 = pulse mode |
| defer_en_i | input | 1 | 1 = defer read-clear until guard window ends |
| rd_i | input | 1 | Flag register read strobe |
| wr_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 1 | Value written to the flag |
| tick_i | input | 1 | One-cycle timebase enable at 32.768 kHz |
| flag_o | output | 1 | Readable alarm flag |
| pull_en_n_o | output | 1 | Active-low open-drain enable: 0 pulls pin low |

## Verification
Two pairs of events can meet in one cycle. A processor read can meet the end of the guard window. A software write of 0 can meet the automatic pulse timeout. The bench places a read on the very cycle the fourth tick is sampled, and again on the cycle just after it, and expects a one-cycle deferral in the first case and an immediate clear in the second. It also drives a clearing write on the cycle the timeout ends. A behavioural model, fed the same stimulus, is compared against both outputs on every clock.

// File: rtl/alarm_flag_pkg.sv
package alarm_flag_pkg;
  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_LATCH = 1'b1
  } alarm_mode_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/tick_window.sv
module tick_window #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = alarm_flag_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/alarm_flag_core.sv
module alarm_flag_core
  import alarm_flag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic match_i,
  input  logic mask_i,
  input  logic latch_mode_i,
  input  logic defer_en_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_data_i,
  input  logic guard_done_i,
  input  logic restore_done_i,
  output logic start_o,
  output logic flag_o,
  output logic pull_en_n_o
);
  alarm_mode_e mode;
  logic flag_q, pull_n_q, pend_q;
  logic set_ev, clr, pend_set, flag_d;
  logic rd_clr, pend_clr, wr_clr, auto_clr;

  always_comb begin
    mode     = alarm_mode_e'(latch_mode_i);
    set_ev   = !flag_q && match_i && !mask_i;
    rd_clr   = (mode == MODE_LATCH) && rd_i && (!defer_en_i || guard_done_i);
    pend_clr = (mode == MODE_LATCH) && pend_q && guard_done_i;
    wr_clr   = (mode == MODE_PULSE) && wr_i && !wr_data_i;
    auto_clr = (mode == MODE_PULSE) && restore_done_i;
    clr      = flag_q && (rd_clr || pend_clr || wr_clr || auto_clr);
    pend_set = flag_q && (mode == MODE_LATCH) && rd_i && defer_en_i && !guard_done_i;
    flag_d   = set_ev || (flag_q && !clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      pull_n_q <= 1'b1;
      pend_q   <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      pull_n_q <= !flag_d;
      if (clr || !flag_q) pend_q <= 1'b0;
      else if (pend_set)  pend_q <= 1'b1;
    end
  end

  assign start_o     = set_ev;
  assign flag_o      = flag_q;
  assign pull_en_n_o = pull_n_q;
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl #(
  parameter int GUARD_TICKS   = 4,
  parameter int RESTORE_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic match_i,
  input  logic mask_i,
  input  logic latch_mode_i,
  input  logic defer_en_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_data_i,
  input  logic tick_i,
  output logic flag_o,
  output logic pull_en_n_o
);
  localparam int NWIN = 2;
  localparam int WIN_LIMIT [NWIN] = '{GUARD_TICKS, RESTORE_TICKS};

  logic start, flag;
  logic [NWIN-1:0] win_done;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    tick_window #(.LIMIT(WIN_LIMIT[g])) u_win (
      .clk    (clk),
      .rst    (rst),
      .start_i(start),
      .run_i  (flag),
      .tick_i (tick_i),
      .done_o (win_done[g])
    );
  end

  alarm_flag_core u_core (
    .clk           (clk),
    .rst           (rst),
    .match_i       (match_i),
    .mask_i        (mask_i),
    .latch_mode_i  (latch_mode_i),
    .defer_en_i    (defer_en_i),
    .rd_i          (rd_i),
    .wr_i          (wr_i),
    .wr_data_i     (wr_data_i),
    .guard_done_i  (win_done[0]),
    .restore_done_i(win_done[1]),
    .start_o       (start),
    .flag_o        (flag),
    .pull_en_n_o   (pull_en_n_o)
  );

  assign flag_o = flag;
endmodule

// File: rtl/alarm_flag_ctl_chk.sv
module alarm_flag_ctl_chk (
  input logic clk,
  input logic rst,
  input logic match_i,
  input logic mask_i,
  input logic latch_mode_i,
  input logic defer_en_i,
  input logic rd_i,
  input logic wr_i,
  input logic wr_data_i,
  input logic tick_i,
  input logic flag_o,
  input logic pull_en_n_o
);
  a_r1_match_sets: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && match_i && !mask_i) |=> flag_o);

  a_r1_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && mask_i) |=> !flag_o);

  a_r2_pin_mirrors_flag: assert property (@(posedge clk) disable iff (rst)
    pull_en_n_o == !flag_o);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_o && latch_mode_i && !defer_en_i && rd_i) |=> !flag_o);

  a_r9_write_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !latch_mode_i && wr_i && !wr_data_i) |=> !flag_o);

  a_r7_latched_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (flag_o && latch_mode_i && !rd_i && !defer_en_i) |=> flag_o);
endmodule

bind alarm_flag_ctl alarm_flag_ctl_chk u_chk (.*);

// File: tb/test_alarm_flag_ctl.sv
module test_alarm_flag_ctl;
  localparam int GT = 4;
  localparam int RT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic match_i = 0, mask_i = 0, latch_mode_i = 0, defer_en_i = 0;
  logic rd_i = 0, wr_i = 0, wr_data_i = 0, tick_i = 0;
  logic flag_o, pull_en_n_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R11";

  int m_flag = 0, m_age = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  alarm_flag_ctl #(.GUARD_TICKS(GT), .RESTORE_TICKS(RT)) i_alarm_flag_ctl (.*);

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_age = 0; m_pend = 0;
    end else if (m_flag == 0) begin
      if (match_i && !mask_i) begin m_flag = 1; m_age = 0; m_pend = 0; end
    end else begin
      bit clr;
      clr = 0;
      if (latch_mode_i) begin
        if (rd_i && (!defer_en_i || m_age >= GT)) clr = 1;
        else if (m_pend == 1 && m_age >= GT)     clr = 1;
        else if (rd_i)                           m_pend = 1;
      end else if ((wr_i && !wr_data_i) || m_age >= RT) begin
        clr = 1;
      end
      if (tick_i) m_age++;
      if (clr) begin m_flag = 0; m_pend = 0; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (flag_o !== m_flag[0] || pull_en_n_o !== !m_flag[0]) begin
        errors++;
        $display("FAIL %s model compare: flag=%b pin_n=%b expected flag=%0d pin_n=%0d",
                 cur_req, flag_o, pull_en_n_o, m_flag, !m_flag[0]);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_match();
    match_i = 1; cyc(); match_i = 0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; cyc(); tick_i = 0; cyc();
    end
  endtask

  task automatic do_read();
    rd_i = 1; cyc(); rd_i = 0;
  endtask

  task automatic do_write(input logic d);
    wr_i = 1; wr_data_i = d; cyc(); wr_i = 0; wr_data_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (%s): actual hung expected finished", cur_req);
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc();
    cur_req = "R11";
    chk("R11 flag after reset", flag_o, 1'b0);
    chk("R11 pin open after reset", pull_en_n_o, 1'b1);

    cur_req = "R1";
    latch_mode_i = 1; mask_i = 1;
    do_match(); cyc();
    chk("R1 masked match", flag_o, 1'b0);
    mask_i = 0;
    do_match();
    chk("R1 unmasked match sets", flag_o, 1'b1);
    cur_req = "R2";
    chk("R2 pin low with flag", pull_en_n_o, 1'b0);

    cur_req = "R7";
    do_write(1'b0); cyc();
    chk("R7 latched write 0 ignored", flag_o, 1'b1);
    cur_req = "R4";
    do_read();
    chk("R4 read clears", flag_o, 1'b0);
    chk("R2 pin open after clear", pull_en_n_o, 1'b1);

    cur_req = "R5";
    defer_en_i = 1;
    do_match(); do_tick(2); do_read(); cyc();
    chk("R5 early read deferred", flag_o, 1'b1);
    do_tick(1);
    chk("R5 still set after 3 ticks", flag_o, 1'b1);
    tick_i = 1; cyc(); tick_i = 0;
    chk("R5 set on 4th tick cycle", flag_o, 1'b1);
    cyc();
    chk("R5 cleared after window", flag_o, 1'b0);

    do_match(); do_tick(3);
    tick_i = 1; rd_i = 1; cyc(); tick_i = 0; rd_i = 0;
    chk("R5 read with 4th tick counts as early", flag_o, 1'b1);
    cyc();
    chk("R5 pending read clears", flag_o, 1'b0);

    cur_req = "R6";
    do_match(); do_tick(4);
    chk("R6 no read keeps flag", flag_o, 1'b1);
    do_read();
    chk("R6 late read clears", flag_o, 1'b0);
    do_match(); do_tick(3);
    tick_i = 1; cyc(); tick_i = 0; rd_i = 1; cyc(); rd_i = 0;
    chk("R6 read right after window clears", flag_o, 1'b0);

    cur_req = "R8";
    latch_mode_i = 0; defer_en_i = 0;
    do_match(); do_read(); do_read();
    chk("R8 pulse-mode read ignored", flag_o, 1'b1);
    cur_req = "R9";
    do_write(1'b1);
    chk("R9 write 1 ignored", flag_o, 1'b1);
    do_write(1'b0);
    chk("R9 write 0 clears", flag_o, 1'b0);

    cur_req = "R10";
    do_match(); do_tick(1);
    chk("R10 set before timeout", flag_o, 1'b1);
    do_tick(1);
    chk("R10 auto restore", flag_o, 1'b0);

    cur_req = "R3";
    do_match(); do_tick(1); do_match(); do_tick(1);
    chk("R3 repeat match ignored, no restart", flag_o, 1'b0);

    cur_req = "R12";
    match_i = 1; tick_i = 1; cyc(); match_i = 0; tick_i = 0; cyc();
    do_tick(1);
    chk("R12 tick in set cycle not counted", flag_o, 1'b1);
    cyc(5);
    chk("R12 no ticks, no restore", flag_o, 1'b1);
    tick_i = 1; cyc(); tick_i = 0; wr_i = 1; wr_data_i = 0; cyc(); wr_i = 0;
    chk("R9 write 0 with timeout same cycle", flag_o, 1'b0);

    cur_req = "R11";
    do_match(); rst = 1; cyc(); rst = 0; cyc();
    chk("R11 reset clears flag", flag_o, 1'b0);
    chk("R11 reset opens pin", pull_en_n_o, 1'b1);
    cyc(2);
    finish_run();
  end
endmodule